// File: doc/BRIEF.md
# Addressed Serial Configuration Chain

This block gives an external controller bit-serial access to a set of configuration and status chains inside a multi-port switch. A transfer is framed by `xfer_i`. On the clock edge where the frame opens, the 6-bit chain address and the direction are sampled. The selected chain's current contents are copied into a shift register, and a down-counter is loaded with that chain's length. Each later cycle in which `bit_vld_i` is high moves one bit. The oldest bit leaves on `sdo_o`, and `sdi_i` enters at the far end of the chain.

Multi-port chains are laid out so that port 0's field reaches `sdo_o` first and serial input enters on port 15's side. After a complete write, the first bit written therefore sits in the most significant bit of port 0's field. Writable chains hold the per-port clock-select bits, the per-port link-control bytes, a global control byte and two impedance words. The read-only chains present a constant identifier, per-port 16-bit good and bad packet counters, and live per-port receive and transmit status. Their values are frozen in the shift register when the read starts. Addresses 8 through 63 select nothing.

Top module: `cfgc_chain_top`

## Requirements
- R1: The address is sampled only on the frame-opening edge (`xfer_i` high after a low cycle). Chains 0..7 have lengths of 32, 16, 16, 2·NP, 32·NP, 16·NP, 8·NP and 8 bits, and the shift counter stops after that many strobes. Chains 1 and 2 are 16-bit words that reset to 16'hE1E1.
- R2: A frame to an address from 8 to 63 keeps `sdo_o` at 0 for the whole frame, and a write to such an address changes no register.
- R3: Every chain is streamed most significant bit first. The first bit is on `sdo_o` in the cycle after the opening edge, and each strobe edge advances one bit. `sdi_i` enters at the port NP-1 end. On the link-control chain (6), port p's byte occupies stream bits 8p..8p+7.
- R4: A writable register changes only on the edge that accepts the final bit of a write frame. A frame closed early leaves it unchanged, and writes to chains 0, 4 and 5 are ignored.
- R5: The counter chain (4) carries, for each port starting with port 0, the bad counter and then the good counter, each MSB first. The values are those held on the opening edge, and reading does not clear them.
- R6: Each counter is 16 bits wide, counts one per cycle its increment input is high, and wraps from 65535 to 0.
- R7: The status chain (5) carries the 12-bit receive fields of ports 0..NP-1, followed by the 4-bit transmit fields of ports 0..NP-1, each MSB first, as sampled on the opening edge.
- R8: The clock-select chain (3) is made of bytes in groups of eight ports: receive-fast byte, then transmit-fast byte. Each byte's MSB is the group's highest port. All bits reset to 0.
- R9: The global control byte (chain 7) resets to 8'hFC, and every link-control byte resets to 8'hC0.
- R10: `sdo_o` is 0 outside a frame and once the chain length is used up. Strobes after that point shift nothing.
- R11: Chain 0 returns the `CHIP_ID` parameter and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_i | input | 1 | Frame active |
| wr_i | input | 1 | Direction at frame start, 1 = write |
| addr_i | input | 6 | Chain address at frame start |
| bit_vld_i | input | 1 | Shift strobe |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| good_inc_i | input | NP | Per-port good packet count pulse |
| bad_inc_i | input | NP | Per-port bad packet count pulse |
| rx_stat_i | input | 12·NP | Live receive status, port p at [12p+11:12p] |
| tx_stat_i | input | 4·NP | Live transmit status, port p at [4p+3:4p] |
| rx_fast_o | output | NP | Receive fast-clock select per port |
| tx_fast_o | output | NP | Transmit fast-clock select per port |
| lctl_o | output | 8·NP | Link-control byte per port, port p at [8p+7:8p] |
| gctl_o | output | 8 | Global control byte |
| impt_o | output | 16 | Impedance trial word |
| imp_o | output | 16 | Impedance word |

## Verification
The first serial bit appears one cycle after the opening edge, and each later bit one cycle after the strobe edge that moves it. A write shows on the register outputs in the cycle after the edge that takes its last bit. Counters move one cycle after each increment pulse, and the status and counter snapshots belong to the opening edge. The bench's behavioural model advances on the same rising edges, and the bench compares `sdo_o` and every register output with it at each falling edge, so each result is examined in exactly the cycle it becomes due.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;
  localparam int ADDR_W = 6;
  localparam int ID_W   = 32;
  localparam int IMP_W  = 16;
  localparam int CNT_W  = 16;
  localparam int RXS_W  = 12;
  localparam int TXS_W  = 4;
  localparam int LCTL_W = 8;
  localparam int GCTL_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    CH_ID   = 6'd0,
    CH_IMPT = 6'd1,
    CH_IMP  = 6'd2,
    CH_SPD  = 6'd3,
    CH_CNT  = 6'd4,
    CH_STAT = 6'd5,
    CH_LCTL = 6'd6,
    CH_GCTL = 6'd7
  } chain_e;
endpackage

// File: rtl/cfgc_crc_counters.sv
module cfgc_crc_counters #(
  parameter int NP = 16,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NP-1:0]     good_inc_i,
  input  logic [NP-1:0]     bad_inc_i,
  output logic [NP*2*CW-1:0] img_o
);
  localparam int PW = 2 * CW;

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [CW-1:0] good_q, good_d, bad_q, bad_d;

    always_comb begin
      good_d = good_inc_i[p] ? good_q + CW'(1) : good_q;
      bad_d  = bad_inc_i[p]  ? bad_q + CW'(1)  : bad_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        good_q <= '0;
        bad_q  <= '0;
      end else begin
        good_q <= good_d;
        bad_q  <= bad_d;
      end
    end

    // port 0 in the most significant slot so it leaves the chain first
    assign img_o[(NP-1-p)*PW +: PW] = {bad_q, good_q};
  end
endmodule

// File: rtl/cfgc_cfg_regs.sv
module cfgc_cfg_regs import cfgc_pkg::*; #(
  parameter int          NP       = 16,
  parameter int          WDW      = 128,
  parameter logic [15:0] IMP_RST  = 16'hE1E1,
  parameter logic [7:0]  LCTL_RST = 8'hC0,
  parameter logic [7:0]  GCTL_RST = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WDW-1:0]    wdata_i,
  output logic [NP-1:0]     rx_fast_o,
  output logic [NP-1:0]     tx_fast_o,
  output logic [NP*8-1:0]   lctl_o,
  output logic [7:0]        gctl_o,
  output logic [15:0]       impt_o,
  output logic [15:0]       imp_o,
  output logic [2*NP-1:0]   spd_img_o,
  output logic [NP*8-1:0]   lctl_img_o
);
  // NP must be a multiple of 8 for the clock-select byte grouping
  localparam int NG = NP / 8;

  logic en_impt, en_imp, en_spd, en_lctl, en_gctl;
  logic [NP-1:0]   rxf_q, txf_q, rxf_d, txf_d;
  logic [NP*8-1:0] lctl_q, lctl_d;
  logic [7:0]      gctl_q;
  logic [15:0]     impt_q, imp_q;

  always_comb begin
    en_impt = 1'b0;
    en_imp  = 1'b0;
    en_spd  = 1'b0;
    en_lctl = 1'b0;
    en_gctl = 1'b0;
    if (wr_stb_i) begin
      case (wr_addr_i)
        CH_IMPT: en_impt = 1'b1;
        CH_IMP:  en_imp  = 1'b1;
        CH_SPD:  en_spd  = 1'b1;
        CH_LCTL: en_lctl = 1'b1;
        CH_GCTL: en_gctl = 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign rxf_d[g*8 +: 8] = wdata_i[(2*NG-1-2*g)*8 +: 8];
    assign txf_d[g*8 +: 8] = wdata_i[(2*NG-2-2*g)*8 +: 8];
    assign spd_img_o[(2*NG-1-2*g)*8 +: 8] = rxf_q[g*8 +: 8];
    assign spd_img_o[(2*NG-2-2*g)*8 +: 8] = txf_q[g*8 +: 8];
  end

  for (genvar p = 0; p < NP; p++) begin : g_lc
    assign lctl_d[p*8 +: 8]              = wdata_i[(NP-1-p)*8 +: 8];
    assign lctl_img_o[(NP-1-p)*8 +: 8]   = lctl_q[p*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_q  <= '0;
      txf_q  <= '0;
      lctl_q <= {NP{LCTL_RST}};
      gctl_q <= GCTL_RST;
      impt_q <= IMP_RST;
      imp_q  <= IMP_RST;
    end else begin
      if (en_spd) begin
        rxf_q <= rxf_d;
        txf_q <= txf_d;
      end
      if (en_lctl) lctl_q <= lctl_d;
      if (en_gctl) gctl_q <= wdata_i[7:0];
      if (en_impt) impt_q <= wdata_i[15:0];
      if (en_imp)  imp_q  <= wdata_i[15:0];
    end
  end

  assign rx_fast_o = rxf_q;
  assign tx_fast_o = txf_q;
  assign lctl_o    = lctl_q;
  assign gctl_o    = gctl_q;
  assign impt_o    = impt_q;
  assign imp_o     = imp_q;
endmodule

// File: rtl/cfgc_shifter.sv
module cfgc_shifter #(
  parameter int MAXL  = 512,
  parameter int LEN_W = 10,
  parameter int WDW   = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             xfer_i,
  input  logic             shift_i,
  input  logic             sdi_i,
  input  logic [MAXL-1:0]  img_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             sdo_o,
  output logic             last_o,
  output logic [WDW-1:0]   wdata_o,
  output logic [LEN_W-1:0] cnt_o
);
  localparam int IDX_W = $clog2(MAXL);

  logic [MAXL-1:0]  sr_q, sr_d, sr_nx;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d, top_pos;
  logic             busy, do_shift;

  assign busy     = (cnt_q != '0);
  assign do_shift = shift_i & busy;
  assign sr_nx    = {sr_q[MAXL-2:0], sdi_i};
  assign top_pos  = len_q - LEN_W'(1);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    len_d = len_q;
    if (start_i) begin
      sr_d  = img_i;
      cnt_d = len_i;
      len_d = len_i;
    end else if (!xfer_i) begin
      cnt_d = '0;
    end else if (do_shift) begin
      sr_d  = sr_nx;
      cnt_d = cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  // output tap sits at the top of the right-justified chain image
  assign sdo_o   = busy & sr_q[top_pos[IDX_W-1:0]];
  assign last_o  = do_shift & (cnt_q == LEN_W'(1));
  assign wdata_o = sr_nx[WDW-1:0];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/cfgc_chain_top.sv
module cfgc_chain_top import cfgc_pkg::*; #(
  parameter int          NP       = 16,
  parameter logic [31:0] CHIP_ID  = 32'h5A3C_0F81,
  parameter logic [15:0] IMP_RST  = 16'hE1E1,
  parameter logic [7:0]  LCTL_RST = 8'hC0,
  parameter logic [7:0]  GCTL_RST = 8'hFC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_i,
  input  logic               wr_i,
  input  logic [5:0]         addr_i,
  input  logic               bit_vld_i,
  input  logic               sdi_i,
  output logic               sdo_o,
  input  logic [NP-1:0]      good_inc_i,
  input  logic [NP-1:0]      bad_inc_i,
  input  logic [NP*12-1:0]   rx_stat_i,
  input  logic [NP*4-1:0]    tx_stat_i,
  output logic [NP-1:0]      rx_fast_o,
  output logic [NP-1:0]      tx_fast_o,
  output logic [NP*8-1:0]    lctl_o,
  output logic [7:0]         gctl_o,
  output logic [15:0]        impt_o,
  output logic [15:0]        imp_o
);
  localparam int CNT_BITS  = 2 * CNT_W * NP;
  localparam int STAT_BITS = (RXS_W + TXS_W) * NP;
  localparam int MAXL      = (CNT_BITS > ID_W) ? CNT_BITS : ID_W;
  localparam int LEN_W     = $clog2(MAXL + 1);
  localparam int WDW       = (LCTL_W * NP > IMP_W) ? LCTL_W * NP : IMP_W;

  logic               active_q, active_d;
  logic               wr_q, wr_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               start, shift, last, wr_stb;
  logic [MAXL-1:0]    img;
  logic [LEN_W-1:0]   len, cnt_q;
  logic [WDW-1:0]     wdata;
  logic [CNT_BITS-1:0]  cnt_img;
  logic [STAT_BITS-1:0] stat_img;
  logic [2*NP-1:0]    spd_img;
  logic [NP*8-1:0]    lctl_img;

  assign start  = xfer_i & ~active_q;
  assign shift  = active_q & xfer_i & bit_vld_i;
  assign wr_stb = last & wr_q;

  always_comb begin
    active_d = xfer_i;
    wr_d     = start ? wr_i   : wr_q;
    addr_d   = start ? addr_i : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
    end else begin
      active_q <= active_d;
      wr_q     <= wr_d;
      addr_q   <= addr_d;
    end
  end

  // receive fields for all ports first, then transmit fields
  for (genvar p = 0; p < NP; p++) begin : g_stat
    assign stat_img[STAT_BITS-1-p*RXS_W -: RXS_W] = rx_stat_i[p*RXS_W +: RXS_W];
    assign stat_img[TXS_W*NP-1-p*TXS_W -: TXS_W]  = tx_stat_i[p*TXS_W +: TXS_W];
  end

  always_comb begin
    img = '0;
    len = '0;
    case (addr_i)
      CH_ID:   begin img = MAXL'(CHIP_ID);  len = LEN_W'(ID_W);      end
      CH_IMPT: begin img = MAXL'(impt_o);   len = LEN_W'(IMP_W);     end
      CH_IMP:  begin img = MAXL'(imp_o);    len = LEN_W'(IMP_W);     end
      CH_SPD:  begin img = MAXL'(spd_img);  len = LEN_W'(2*NP);      end
      CH_CNT:  begin img = MAXL'(cnt_img);  len = LEN_W'(CNT_BITS);  end
      CH_STAT: begin img = MAXL'(stat_img); len = LEN_W'(STAT_BITS); end
      CH_LCTL: begin img = MAXL'(lctl_img); len = LEN_W'(LCTL_W*NP); end
      CH_GCTL: begin img = MAXL'(gctl_o);   len = LEN_W'(GCTL_W);    end
      default: ;
    endcase
  end

  cfgc_shifter #(.MAXL(MAXL), .LEN_W(LEN_W), .WDW(WDW)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .xfer_i  (xfer_i),
    .shift_i (shift),
    .sdi_i   (sdi_i),
    .img_i   (img),
    .len_i   (len),
    .sdo_o   (sdo_o),
    .last_o  (last),
    .wdata_o (wdata),
    .cnt_o   (cnt_q)
  );

  cfgc_crc_counters #(.NP(NP), .CW(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .good_inc_i (good_inc_i),
    .bad_inc_i  (bad_inc_i),
    .img_o      (cnt_img)
  );

  cfgc_cfg_regs #(
    .NP(NP), .WDW(WDW), .IMP_RST(IMP_RST), .LCTL_RST(LCTL_RST), .GCTL_RST(GCTL_RST)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb_i   (wr_stb),
    .wr_addr_i  (addr_q),
    .wdata_i    (wdata),
    .rx_fast_o  (rx_fast_o),
    .tx_fast_o  (tx_fast_o),
    .lctl_o     (lctl_o),
    .gctl_o     (gctl_o),
    .impt_o     (impt_o),
    .imp_o      (imp_o),
    .spd_img_o  (spd_img),
    .lctl_img_o (lctl_img)
  );
endmodule

// File: rtl/cfgc_chain_chk.sv
module cfgc_chain_chk #(
  parameter int NP    = 16,
  parameter int LEN_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             xfer_i,
  input logic             bit_vld_i,
  input logic             sdo_o,
  input logic             active_q,
  input logic             start,
  input logic             wr_stb,
  input logic [5:0]       addr_i,
  input logic [LEN_W-1:0] cnt_q,
  input logic [7:0]       gctl_o,
  input logic [NP-1:0]    rx_fast_o,
  input logic [NP-1:0]    tx_fast_o,
  input logic [NP*8-1:0]  lctl_o,
  input logic [15:0]      impt_o,
  input logic [15:0]      imp_o,
  input logic [15:0]      good0,
  input logic             good_inc0
);
  assert_global_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && addr_i == 6'd7) |=> (cnt_q == LEN_W'(8)));

  assert_unmapped_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && addr_i > 6'd7) |=> (cnt_q == '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && xfer_i && bit_vld_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - LEN_W'(1)));

  assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable({gctl_o, rx_fast_o, tx_fast_o, lctl_o, impt_o, imp_o}));

  assert_counter_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    good_inc0 |=> (good0 == $past(good0) + 16'd1));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> !sdo_o);
endmodule

bind cfgc_chain_top cfgc_chain_chk #(.NP(NP), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfer_i    (xfer_i),
  .bit_vld_i (bit_vld_i),
  .sdo_o     (sdo_o),
  .active_q  (active_q),
  .start     (start),
  .wr_stb    (wr_stb),
  .addr_i    (addr_i),
  .cnt_q     (cnt_q),
  .gctl_o    (gctl_o),
  .rx_fast_o (rx_fast_o),
  .tx_fast_o (tx_fast_o),
  .lctl_o    (lctl_o),
  .impt_o    (impt_o),
  .imp_o     (imp_o),
  .good0     (cnt_img[(NP-1)*32 +: 16]),
  .good_inc0 (good_inc_i[0])
);

// File: tb/tb_cfgc_chain_top.sv
`timescale 1ns/1ps
module tb_cfgc_chain_top;
  localparam int NP = 16;
  localparam logic [31:0] ID = 32'h5A3C_0F81;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer = 1'b0, wr = 1'b0, vld = 1'b0, sdi = 1'b0;
  logic [5:0] addr = '0;
  logic [NP-1:0] ginc = '0, binc = '0;
  logic [NP*12-1:0] rxs = '0;
  logic [NP*4-1:0]  txs = '0;
  logic sdo;
  logic [NP-1:0] rxf, txf;
  logic [NP*8-1:0] lctl;
  logic [7:0] gctl;
  logic [15:0] impt, imp;

  always #2 clk = ~clk;

  cfgc_chain_top #(.NP(NP), .CHIP_ID(ID)) dut (
    .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .wr_i(wr), .addr_i(addr),
    .bit_vld_i(vld), .sdi_i(sdi), .sdo_o(sdo), .good_inc_i(ginc), .bad_inc_i(binc),
    .rx_stat_i(rxs), .tx_stat_i(txs), .rx_fast_o(rxf), .tx_fast_o(txf),
    .lctl_o(lctl), .gctl_o(gctl), .impt_o(impt), .imp_o(imp));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // ---------------- reference model ----------------
  bit m_rxf[NP], m_txf[NP];
  int m_lctl[NP], m_good[NP], m_bad[NP];
  int m_gctl, m_impt, m_imp, m_addr, m_rem;
  bit m_act, m_wr, m_st;
  bit q_out[$];
  bit q_in[$];
  bit wbits[$];

  task automatic m_reset();
    for (int p = 0; p < NP; p++) begin
      m_rxf[p] = 0; m_txf[p] = 0; m_lctl[p] = 'hC0; m_good[p] = 0; m_bad[p] = 0;
    end
    m_gctl = 'hFC; m_impt = 'hE1E1; m_imp = 'hE1E1;
    m_addr = 0; m_rem = 0; m_act = 0; m_wr = 0;
    q_out.delete(); q_in.delete();
  endtask

  task automatic push(input int v, input int w);
    for (int i = w - 1; i >= 0; i--) q_out.push_back(v[i]);
  endtask

  function automatic int take(input int off, input int w);
    int v = 0;
    for (int i = 0; i < w; i++) v = (v << 1) | int'(q_in[off + i]);
    return v;
  endfunction

  function automatic int m_len(input int a);
    case (a)
      0: return 32; 1, 2: return 16; 3: return 2 * NP; 4: return 32 * NP;
      5: return 16 * NP; 6: return 8 * NP; 7: return 8; default: return 0;
    endcase
  endfunction

  task automatic m_build(input int a);
    q_out.delete(); q_in.delete();
    case (a)
      0: push(int'(ID), 32);
      1: push(m_impt, 16);
      2: push(m_imp, 16);
      3: for (int k = 0; k < 2 * NP; k++) begin
           int b = k / 8;
           int pp = (b / 2) * 8 + 7 - (k % 8);
           q_out.push_back((b % 2 == 0) ? m_rxf[pp] : m_txf[pp]);
         end
      4: for (int p = 0; p < NP; p++) begin push(m_bad[p], 16); push(m_good[p], 16); end
      5: begin
           for (int p = 0; p < NP; p++) push(int'(rxs[p*12 +: 12]), 12);
           for (int p = 0; p < NP; p++) push(int'(txs[p*4 +: 4]), 4);
         end
      6: for (int p = 0; p < NP; p++) push(m_lctl[p], 8);
      7: push(m_gctl, 8);
      default: ;
    endcase
  endtask

  task automatic m_apply();
    case (m_addr)
      1: m_impt = take(0, 16);
      2: m_imp  = take(0, 16);
      3: for (int k = 0; k < 2 * NP; k++) begin
           int b = k / 8;
           int pp = (b / 2) * 8 + 7 - (k % 8);
           if (b % 2 == 0) m_rxf[pp] = q_in[k]; else m_txf[pp] = q_in[k];
         end
      6: for (int p = 0; p < NP; p++) m_lctl[p] = take(8 * p, 8);
      7: m_gctl = take(0, 8);
      default: ;
    endcase
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      m_st = xfer && !m_act;
      if (!xfer) m_rem = 0;
      else if (m_act && vld && m_rem > 0) begin
        q_in.push_back(sdi);
        void'(q_out.pop_front());
        m_rem--;
        if (m_rem == 0 && m_wr) m_apply();
      end
      if (m_st) begin
        m_addr = int'(addr); m_wr = wr; m_rem = m_len(m_addr);
        m_build(m_addr);
      end
      for (int p = 0; p < NP; p++) begin
        if (ginc[p]) m_good[p] = (m_good[p] + 1) & 'hFFFF;
        if (binc[p]) m_bad[p]  = (m_bad[p] + 1) & 'hFFFF;
      end
      m_act = xfer;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string sdo_tag(input int a, input int rem);
    if (rem == 0) return "R10";
    case (a)
      0: return "R11"; 1, 2: return "R1"; 3: return "R8"; 4: return "R5/R6";
      5: return "R7"; 6: return "R3"; 7: return "R9"; default: return "R2";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e_sdo;
      logic [NP-1:0] e_rxf, e_txf;
      logic [NP*8-1:0] e_l;
      e_sdo = (m_rem > 0) ? q_out[0] : 1'b0;
      chk(sdo === e_sdo, sdo_tag(m_addr, m_rem), 256'(sdo), 256'(e_sdo));
      for (int p = 0; p < NP; p++) begin
        e_rxf[p] = m_rxf[p]; e_txf[p] = m_txf[p]; e_l[p*8 +: 8] = 8'(m_lctl[p]);
      end
      chk({rxf, txf, lctl, gctl, impt, imp} ===
          {e_rxf, e_txf, e_l, 8'(m_gctl), 16'(m_impt), 16'(m_imp)}, "R4",
          256'({rxf, txf, lctl, gctl, impt, imp}),
          256'({e_rxf, e_txf, e_l, 8'(m_gctl), 16'(m_impt), 16'(m_imp)}));
    end
  end

  // ---------------- stimulus ----------------
  task automatic load_bits(input logic [511:0] v, input int n);
    wbits.delete();
    for (int i = n - 1; i >= 0; i--) wbits.push_back(v[i]);
  endtask

  task automatic frame(input int a, input bit w, input int nbits, input int gap);
    @(negedge clk);
    addr = 6'(a); wr = w; xfer = 1'b1; vld = 1'b0;
    @(negedge clk);
    addr = 6'h2A;
    for (int i = 0; i < nbits; i++) begin
      if (gap > 0 && i % gap == 1) begin vld = 1'b0; @(negedge clk); end
      vld = 1'b1;
      sdi = (i < wbits.size()) ? wbits[i] : 1'((i * 7 + 3) % 5 == 0);
      @(negedge clk);
    end
    vld = 1'b0; xfer = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gctl === 8'hFC, "R9", 256'(gctl), 256'hFC);
    chk(lctl === {NP{8'hC0}}, "R9", 256'(lctl), 256'({NP{8'hC0}}));
    chk({rxf, txf} === '0, "R8", 256'({rxf, txf}), 256'h0);
    chk({impt, imp} === 32'hE1E1_E1E1, "R1", 256'({impt, imp}), 256'hE1E1E1E1);
    chk(sdo === 1'b0, "R10", 256'(sdo), 256'h0);

    wbits.delete();
    frame(7, 0, 8, 0);                       // R9 reset read
    frame(0, 0, 32, 0);                      // R11 identifier
    load_bits(512'hA5C3_3C5A, 32); frame(3, 1, 32, 0);   // R8 write
    wbits.delete(); frame(3, 0, 32, 3);
    load_bits(512'h3A, 8); frame(7, 1, 8, 3);            // R9 global write
    load_bits(512'h1234, 16); frame(1, 1, 16, 0);        // R1 impedance
    load_bits(512'hBEEF, 16); frame(2, 1, 16, 2);
    load_bits(512'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 128);
    frame(6, 1, 128, 0);                     // R3 link control write
    wbits.delete(); frame(6, 0, 128, 0);
    load_bits(512'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128);
    frame(6, 1, 40, 0);                      // R4 aborted write
    wbits.delete(); frame(6, 0, 128, 4);
    load_bits(512'hDEAD_BEEF, 32); frame(9, 1, 32, 0);   // R2 unmapped write
    wbits.delete(); frame(40, 0, 16, 0);                 // R2 unmapped read
    load_bits(512'hFFFF_FFFF, 32); frame(0, 1, 32, 0);   // R11 not writable
    frame(5, 1, 64, 0);                      // R4 read-only write ignored

    for (int p = 0; p < NP; p++) begin
      rxs[p*12 +: 12] = 12'(p * 293 + 17);
      txs[p*4 +: 4]   = 4'(p * 5 + 1);
    end
    @(negedge clk);
    fork
      begin wbits.delete(); frame(5, 0, 16 * NP, 0); end  // R7 status snapshot
      begin repeat (30) @(negedge clk); rxs = ~rxs; txs = ~txs; end
    join

    fork
      frame(4, 0, 32 * NP, 0);               // R5 counters with live pulses
      for (int i = 0; i < 200; i++) begin
        ginc = NP'(i * 13); binc = NP'(i * 7 + 1);
        @(negedge clk);
      end
    join
    ginc = '0; binc = '0;
    frame(4, 0, 32 * NP, 5);                 // R5 counters not cleared

    load_bits(512'h5C, 8); frame(7, 1, 12, 0);            // R10 extra strobes
    wbits.delete(); frame(7, 0, 12, 0);

    ginc = '0; ginc[3] = 1'b1; binc[0] = 1'b1;            // R6 wrap
    repeat (65537) @(negedge clk);
    ginc = '0; binc = '0;
    frame(4, 0, 32 * NP, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule